// File: doc/BRIEF.md
# Masked Move-Priority Generator for One Board Line

This block models a single line of a board as a row of `N` cells and produces, each cycle, the best candidate move on that line. Every cell holds a piece kind and a move priority. An occupied cell attacks its immediate neighbours. A sliding piece's attack also keeps travelling in the same direction through empty cells. It stops at the first occupied cell, and that cell is itself attacked as a capture. Each target cell keeps the best of the attacks arriving on it, and a line-wide arbiter then selects the best move of all cells.

A search controller walks a move tree with the block. The controller reads the winning move and explores it. When it takes that move back, it names the target and source cells, and the block sets one mask bit for that pair. The next-best move then wins. The mask sits between the attack propagation path and the per-cell selection logic. A masked move therefore never stops a slider's attack from reaching the cells beyond it. When no unmasked move remains anywhere on the line, every cell reports the lowest score and the block raises `exhausted`. A synchronous clear empties the whole mask when a new position is loaded.

Move selection is purely combinational from the board, priority and mask inputs. Only the mask is stored.

Top module: `move_prio_line`

## Requirements
- R1: A piece of kind step (`piece_kind` code 01) attacks only the cells at index distance one from it. Its attack is never forwarded further.
- R2: A piece of kind slide (`piece_kind` code 1x) attacks every cell in both directions up to and including the first occupied cell. Any occupied cell (code other than 00) stops forwarding.
- R3: Masking a move does not stop propagation. With a slider's move into an empty cell masked, its moves into the cells beyond that cell are still reported.
- R4: Within one target cell, the unmasked attack with the largest priority wins. On equal priority, the lower source index wins.
- R5: Across the line, the cell move with the largest priority is output on `best_tgt`, `best_src` and `best_prio` in the same cycle as the inputs. On equal priority, the lower target index wins.
- R6: A piece with priority 0 produces no move, although it still occupies its cell. When no unmasked move with nonzero priority exists, `exhausted` is 1 and `best_prio`, `best_tgt` and `best_src` are all 0. Otherwise `exhausted` is 0 and `best_prio` is nonzero.
- R7: A take-back (`tb_en` high at a rising edge) sets the mask bit for (`tb_tgt`, `tb_src`) from the next edge on. A masked move is never output, and a mask bit never clears except by `mask_clr` or reset.
- R8: `mask_clr` high at a rising edge clears every mask bit. If a take-back arrives in the same cycle, the clear wins.
- R9: Asynchronous active-low reset clears every mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mask register |
| rst_n | input | 1 | Asynchronous active-low reset |
| piece_kind | input | 2*N | Two bits per cell: 00 empty, 01 step, 1x slide |
| piece_prio | input | PW*N | Move priority of the piece on each cell (0 means no move) |
| tb_en | input | 1 | Take-back strobe |
| tb_tgt | input | IW | Target cell of the move taken back |
| tb_src | input | IW | Source cell of the move taken back |
| mask_clr | input | 1 | Synchronous clear of all mask bits |
| exhausted | output | 1 | No unmasked move remains on the line |
| best_tgt | output | IW | Target cell of the winning move |
| best_src | output | IW | Source cell of the winning move |
| best_prio | output | PW | Priority of the winning move (0 when exhausted) |

## Verification
Some properties are checked on every cycle. The exhausted flag and the winning priority must agree. A reported move is never a masked pair and never a move of a piece onto itself. Mask bits are set by take-backs, cleared only by clear or reset, and a take-back always lands in the named bit. Other behaviour depends on geometry and can only be shown by the bench's scenarios, which compare against a brute-force model of the line. These scenarios cover stepper reach, slider reach up to a blocker, continued propagation past a masked cell, both tie-breaking orders, zero-priority pieces and complete drains of the move list.

// File: rtl/move_prio_pkg.sv
package move_prio_pkg;

   // Piece kind encoding, two bits per cell
   localparam logic [1:0] KIND_EMPTY = 2'b00;
   localparam logic [1:0] KIND_STEP  = 2'b01;
   localparam logic [1:0] KIND_SLIDE = 2'b10;

   function automatic logic kind_occupied(input logic [1:0] k);
      return |k;
   endfunction

   function automatic logic kind_slides(input logic [1:0] k);
      return k[1];
   endfunction

endpackage

// File: rtl/mp_ray.sv
// Attack propagation along one direction of the line.
// arrive[c][s] = 1 when the piece on cell s attacks cell c from this side.
module mp_ray #(
   parameter int N           = 8,
   parameter bit TOWARD_HIGH = 1'b1
) (
   input  logic [N-1:0]         occ,
   input  logic [N-1:0]         slide,
   output logic [N-1:0][N-1:0]  arrive
);

   generate
      if (TOWARD_HIGH) begin : g_high
         always_comb begin
            logic [N-1:0] carry;
            carry = '0;
            for (int c = 0; c < N; c++) begin
               arrive[c] = carry;
               carry = (carry & slide & {N{~occ[c]}})
                     | (occ[c] ? (N'(1) << c) : '0);
            end
         end
      end else begin : g_low
         always_comb begin
            logic [N-1:0] carry;
            carry = '0;
            for (int c = N - 1; c >= 0; c--) begin
               arrive[c] = carry;
               carry = (carry & slide & {N{~occ[c]}})
                     | (occ[c] ? (N'(1) << c) : '0);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mp_cell_pick.sv
// Best unmasked attack landing on one cell; 0 is the sentinel score.
module mp_cell_pick #(
   parameter int N  = 8,
   parameter int PW = 4,
   parameter int IW = 3
) (
   input  logic [N-1:0]          cand,
   input  logic [N-1:0][PW-1:0]  prio,
   output logic [PW-1:0]         score,
   output logic [IW-1:0]         src
);

   always_comb begin
      score = '0;
      src   = '0;
      for (int s = 0; s < N; s++) begin
         if (cand[s] && (prio[s] > score)) begin
            score = prio[s];
            src   = IW'(s);
         end
      end
   end

endmodule

// File: rtl/mp_arbiter.sv
// Line-wide selection over per-cell scores; lowest cell wins a tie.
module mp_arbiter #(
   parameter int N  = 8,
   parameter int PW = 4,
   parameter int IW = 3
) (
   input  logic [N-1:0][PW-1:0]  scores,
   input  logic [N-1:0][IW-1:0]  srcs,
   output logic [IW-1:0]         win_tgt,
   output logic [IW-1:0]         win_src,
   output logic [PW-1:0]         win_prio,
   output logic                  none_left
);

   logic [N-1:0] cell_live;

   always_comb begin
      for (int c = 0; c < N; c++) begin
         cell_live[c] = |scores[c];
      end
   end

   assign none_left = ~|cell_live;

   always_comb begin
      win_tgt  = '0;
      win_src  = '0;
      win_prio = '0;
      for (int c = 0; c < N; c++) begin
         if (scores[c] > win_prio) begin
            win_prio = scores[c];
            win_tgt  = IW'(c);
            win_src  = srcs[c];
         end
      end
   end

endmodule

// File: rtl/mp_mask_reg.sv
// One mask bit per (target, source) pair.
module mp_mask_reg #(
   parameter int N  = 8,
   parameter int IW = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  set_en,
   input  logic [IW-1:0]         set_tgt,
   input  logic [IW-1:0]         set_src,
   output logic [N-1:0][N-1:0]   mask_q
);

   logic in_range;
   assign in_range = (int'(set_tgt) < N) && (int'(set_src) < N);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (clr) begin
         mask_q <= '0;
      end else if (set_en && in_range) begin
         mask_q[set_tgt][set_src] <= 1'b1;
      end
   end

endmodule

// File: rtl/move_prio_line.sv
module move_prio_line
   import move_prio_pkg::*;
#(
   parameter int N  = 8,
   parameter int PW = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2*N-1:0]    piece_kind,
   input  logic [PW*N-1:0]   piece_prio,
   input  logic              tb_en,
   input  logic [IW-1:0]     tb_tgt,
   input  logic [IW-1:0]     tb_src,
   input  logic              mask_clr,
   output logic              exhausted,
   output logic [IW-1:0]     best_tgt,
   output logic [IW-1:0]     best_src,
   output logic [PW-1:0]     best_prio
);

   generate
      if (N < 2) begin : g_bad_n
         $error("move_prio_line: N must be at least 2");
      end
      if (PW < 1) begin : g_bad_pw
         $error("move_prio_line: PW must be at least 1");
      end
   endgenerate

   logic [N-1:0]          occ_v;
   logic [N-1:0]          slide_v;
   logic [N-1:0][PW-1:0]  prio_a;
   logic [N-1:0][N-1:0]   arr_hi;
   logic [N-1:0][N-1:0]   arr_lo;
   logic [N-1:0][N-1:0]   mask_q;
   logic [N-1:0][N-1:0]   cand;
   logic [N-1:0][PW-1:0]  cell_score;
   logic [N-1:0][IW-1:0]  cell_src;

   assign prio_a = piece_prio;

   genvar gc;
   generate
      for (gc = 0; gc < N; gc++) begin : g_decode
         assign occ_v[gc]   = kind_occupied(piece_kind[2*gc +: 2]);
         assign slide_v[gc] = kind_slides(piece_kind[2*gc +: 2]);
      end
   endgenerate

   // Propagation sees every attack: no mask on this path
   mp_ray #(.N(N), .TOWARD_HIGH(1'b1)) u_ray_hi (
      .occ    (occ_v),
      .slide  (slide_v),
      .arrive (arr_hi)
   );

   mp_ray #(.N(N), .TOWARD_HIGH(1'b0)) u_ray_lo (
      .occ    (occ_v),
      .slide  (slide_v),
      .arrive (arr_lo)
   );

   mp_mask_reg #(.N(N), .IW(IW)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (mask_clr),
      .set_en  (tb_en),
      .set_tgt (tb_tgt),
      .set_src (tb_src),
      .mask_q  (mask_q)
   );

   // Mask applied only in front of each cell's selection
   generate
      for (gc = 0; gc < N; gc++) begin : g_cell
         assign cand[gc] = (arr_hi[gc] | arr_lo[gc]) & ~mask_q[gc];

         mp_cell_pick #(.N(N), .PW(PW), .IW(IW)) u_pick (
            .cand  (cand[gc]),
            .prio  (prio_a),
            .score (cell_score[gc]),
            .src   (cell_src[gc])
         );
      end
   endgenerate

   mp_arbiter #(.N(N), .PW(PW), .IW(IW)) u_arb (
      .scores    (cell_score),
      .srcs      (cell_src),
      .win_tgt   (best_tgt),
      .win_src   (best_src),
      .win_prio  (best_prio),
      .none_left (exhausted)
   );

endmodule

// File: rtl/move_prio_line_chk.sv
module move_prio_line_chk #(
   parameter int N  = 8,
   parameter int PW = 4,
   parameter int IW = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tb_en,
   input logic [IW-1:0]     tb_tgt,
   input logic [IW-1:0]     tb_src,
   input logic              mask_clr,
   input logic [N*N-1:0]    mask_flat,
   input logic              exhausted,
   input logic [IW-1:0]     best_tgt,
   input logic [IW-1:0]     best_src,
   input logic [PW-1:0]     best_prio
);

   AST_EXHAUST_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      exhausted |-> (best_prio == '0)); // R6

   AST_LIVE_IS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !exhausted |-> (best_prio != '0)); // R6

   AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !exhausted |-> !mask_flat[int'(best_tgt)*N + int'(best_src)]); // R7

   AST_NO_SELF_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      !exhausted |-> (best_tgt != best_src)); // R1

   AST_TAKEBACK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (tb_en && !mask_clr && (int'(tb_tgt) < N) && (int'(tb_src) < N))
      |=> mask_flat[int'($past(tb_tgt))*N + int'($past(tb_src))]); // R7

   AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mask_clr) |-> (($past(mask_flat) & ~mask_flat) == '0)); // R7

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      mask_clr |=> (mask_flat == '0)); // R8

   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_EMPTY: assert (mask_flat == '0 || $isunknown(mask_flat)); // R9
      end
   end

endmodule

bind move_prio_line move_prio_line_chk #(.N(N), .PW(PW), .IW(IW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tb_en     (tb_en),
   .tb_tgt    (tb_tgt),
   .tb_src    (tb_src),
   .mask_clr  (mask_clr),
   .mask_flat (mask_q),
   .exhausted (exhausted),
   .best_tgt  (best_tgt),
   .best_src  (best_src),
   .best_prio (best_prio)
);

// File: tb/move_prio_line_bench.sv
module move_prio_line_bench;

   localparam int N  = 8;
   localparam int PW = 4;
   localparam int IW = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2*N-1:0]    piece_kind = '0;
   logic [PW*N-1:0]   piece_prio = '0;
   logic              tb_en = 1'b0;
   logic [IW-1:0]     tb_tgt = '0;
   logic [IW-1:0]     tb_src = '0;
   logic              mask_clr = 1'b0;
   logic              exhausted;
   logic [IW-1:0]     best_tgt;
   logic [IW-1:0]     best_src;
   logic [PW-1:0]     best_prio;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   logic [1:0]    bk [N];
   logic [PW-1:0] bp [N];
   bit            bm [N][N];

   always #2.5 clk = ~clk;

   move_prio_line u_move_prio_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .piece_kind (piece_kind),
      .piece_prio (piece_prio),
      .tb_en      (tb_en),
      .tb_tgt     (tb_tgt),
      .tb_src     (tb_src),
      .mask_clr   (mask_clr),
      .exhausted  (exhausted),
      .best_tgt   (best_tgt),
      .best_src   (best_src),
      .best_prio  (best_prio)
   );

   // Brute-force reference built from the requirements
   function automatic bit attacks(int t, int s);
      int lo, hi;
      if (bk[s] == 2'b00 || s == t) return 1'b0;
      if (t == s + 1 || t == s - 1) return 1'b1;
      if (!bk[s][1]) return 1'b0;
      lo = (t < s) ? t : s;
      hi = (t < s) ? s : t;
      for (int k = lo + 1; k < hi; k++) begin
         if (bk[k] != 2'b00) return 1'b0;
      end
      return 1'b1;
   endfunction

   function automatic void model(output int et, output int es, output int ep, output bit ex);
      et = 0; es = 0; ep = 0;
      for (int t = 0; t < N; t++) begin
         for (int s = 0; s < N; s++) begin
            if (attacks(t, s) && !bm[t][s] && int'(bp[s]) > ep) begin
               ep = int'(bp[s]); et = t; es = s;
            end
         end
      end
      ex = (ep == 0);
   endfunction

   task automatic drive_board();
      for (int i = 0; i < N; i++) begin
         piece_kind[2*i +: 2]   = bk[i];
         piece_prio[PW*i +: PW] = bp[i];
      end
   endtask

   task automatic new_board();
      for (int i = 0; i < N; i++) begin
         bk[i] = 2'b00; bp[i] = '0;
      end
   endtask

   task automatic compare(string tag, int et, int es, int ep, bit ex);
      n_checks++;
      if (int'(best_tgt) != et || int'(best_src) != es ||
          int'(best_prio) != ep || exhausted != ex) begin
         n_errors++;
         $display("FAIL %s: got tgt=%0d src=%0d prio=%0d exh=%0b, expected tgt=%0d src=%0d prio=%0d exh=%0b",
                  tag, best_tgt, best_src, best_prio, exhausted, et, es, ep, ex);
      end
   endtask

   // Load board at a falling edge and check combinational result
   task automatic load_and_check(string tag);
      int et, es, ep; bit ex;
      @(negedge clk);
      drive_board();
      #1;
      model(et, es, ep, ex);
      compare(tag, et, es, ep, ex);
   endtask

   task automatic check_model(string tag);
      int et, es, ep; bit ex;
      #1;
      model(et, es, ep, ex);
      compare(tag, et, es, ep, ex);
   endtask

   task automatic check_exp(string tag, int et, int es, int ep, bit ex);
      #1;
      compare(tag, et, es, ep, ex);
   endtask

   task automatic take_back(int t, int s);
      @(negedge clk);
      tb_en = 1'b1; tb_tgt = IW'(t); tb_src = IW'(s);
      @(negedge clk);
      tb_en = 1'b0;
      bm[t][s] = 1'b1;
   endtask

   task automatic clear_mask(bit with_tb, int t, int s);
      @(negedge clk);
      mask_clr = 1'b1;
      tb_en = with_tb; tb_tgt = IW'(t); tb_src = IW'(s);
      @(negedge clk);
      mask_clr = 1'b0; tb_en = 1'b0;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) bm[i][j] = 1'b0;
   endtask

   // Take back the winner repeatedly until the line is exhausted
   task automatic drain(string tag);
      int et, es, ep; bit ex;
      for (int k = 0; k < 2*N*N; k++) begin
         check_model(tag);
         model(et, es, ep, ex);
         if (ex) break;
         take_back(et, es);
      end
   endtask

   task automatic t_reset();
      new_board();
      load_and_check("R9 R6 reset empty line");
      check_exp("R6 empty line exhausted", 0, 0, 0, 1'b1);
   endtask

   task automatic t_step();
      clear_mask(1'b0, 0, 0);
      new_board();
      bk[3] = 2'b01; bp[3] = 4'd5;
      load_and_check("R1 stepper");
      check_exp("R1 stepper lower neighbour", 2, 3, 5, 1'b0);
      take_back(2, 3);
      check_exp("R7 R1 stepper upper neighbour", 4, 3, 5, 1'b0);
      take_back(4, 3);
      check_exp("R1 R6 stepper reach ends", 0, 0, 0, 1'b1);
   endtask

   task automatic t_slide_block();
      clear_mask(1'b0, 0, 0);
      new_board();
      bk[0] = 2'b10; bp[0] = 4'd7;
      bk[4] = 2'b01; bp[4] = 4'd1;
      load_and_check("R2 slider with blocker");
      check_exp("R2 slider first target", 1, 0, 7, 1'b0);
      drain("R2 slider blocked drain");
   endtask

   task automatic t_mask_propagate();
      clear_mask(1'b0, 0, 0);
      new_board();
      bk[0] = 2'b10; bp[0] = 4'd7;
      load_and_check("R3 lone slider");
      take_back(1, 0);
      check_exp("R3 past masked cell", 2, 0, 7, 1'b0);
      take_back(2, 0);
      check_exp("R3 past two masked cells", 3, 0, 7, 1'b0);
      drain("R3 R2 lone slider drain");
   endtask

   task automatic t_ties();
      clear_mask(1'b0, 0, 0);
      new_board();
      bk[3] = 2'b01; bp[3] = 4'd6;
      bk[5] = 2'b01; bp[5] = 4'd6;
      load_and_check("R5 tie lowest target");
      check_exp("R5 tie lowest target", 2, 3, 6, 1'b0);
      take_back(2, 3);
      check_exp("R4 tie lowest source", 4, 3, 6, 1'b0);
      take_back(4, 3);
      check_exp("R4 second source", 4, 5, 6, 1'b0);
      take_back(4, 5);
      check_exp("R4 remaining", 6, 5, 6, 1'b0);
      drain("R4 tie drain");
   endtask

   task automatic t_priority();
      clear_mask(1'b0, 0, 0);
      new_board();
      bk[1] = 2'b01; bp[1] = 4'd2;
      bk[6] = 2'b01; bp[6] = 4'd9;
      load_and_check("R5 priority over index");
      check_exp("R5 higher priority wins", 5, 6, 9, 1'b0);
      new_board();
      bk[2] = 2'b11; bp[2] = 4'd3;
      bk[3] = 2'b01; bp[3] = 4'd8;
      bk[6] = 2'b10; bp[6] = 4'd15;
      load_and_check("R4 R5 mixed board");
      drain("R4 R5 mixed drain");
   endtask

   task automatic t_zero_prio();
      clear_mask(1'b0, 0, 0);
      new_board();
      bk[4] = 2'b01; bp[4] = 4'd0;
      load_and_check("R6 zero priority piece");
      check_exp("R6 zero priority gives no move", 0, 0, 0, 1'b1);
      bk[0] = 2'b10; bp[0] = 4'd2;
      bk[3] = 2'b01; bp[3] = 4'd0;
      load_and_check("R6 zero priority still blocks");
      drain("R6 R2 zero priority blocker drain");
   endtask

   task automatic t_clear();
      clear_mask(1'b0, 0, 0);
      new_board();
      bk[0] = 2'b10; bp[0] = 4'd7;
      load_and_check("R8 clear setup");
      take_back(1, 0);
      take_back(2, 0);
      check_exp("R8 masks before clear", 3, 0, 7, 1'b0);
      clear_mask(1'b0, 0, 0);
      check_exp("R8 clear restores", 1, 0, 7, 1'b0);
      take_back(1, 0);
      clear_mask(1'b1, 1, 0);
      check_exp("R8 clear beats take-back", 1, 0, 7, 1'b0);
   endtask

   task automatic t_reset_mid();
      take_back(1, 0);
      check_exp("R9 mask before reset", 2, 0, 7, 1'b0);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) bm[i][j] = 1'b0;
      check_exp("R9 reset clears mask", 1, 0, 7, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      check_exp("R9 after reset release", 1, 0, 7, 1'b0);
   endtask

   initial begin
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) bm[i][j] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_step();
      t_slide_block();
      t_mask_propagate();
      t_ties();
      t_priority();
      t_zero_prio();
      t_clear();
      t_reset_mid();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: got no completion, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

endmodule